// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line. The line idles high. A frame is one low start bit, then the data bits with the least significant bit first, then one stop bit. The block does not use a bit clock. It uses a one-cycle sampling strobe, supplied from outside, that pulses eight times per nominal bit period. Before the line is examined it passes through a chain of flip-flops that synchronises it to the local clock.

A falling edge is treated only as a candidate start. The start is accepted after four consecutive low samples on strobe pulses, which places the receiver near the middle of the start bit. From there every later bit is sampled a fixed number of strobes after the previous one, so each sample falls near the centre of its bit.

The bits are shifted into a shift register. When the stop-bit sample is taken, the assembled byte is copied to an output holding register and a full flag is raised. The host acknowledges the byte with a read pulse, which clears the full flag. If a new byte arrives while the previous one is still unacknowledged, the new byte replaces it and a sticky overrun flag is raised. A separate status-read pulse clears the overrun flag.

Top module: `serial_rx_x8`

## Requirements
- R1: After reset, `rx_byte` is 0, and `byte_full` and `overrun` are both 0.
- R2: `rx_in` passes through SYNC_STAGES (default 2) flip-flops, each reset to 1, before the framing logic uses it. A level on `rx_in` therefore influences framing decisions only from the SYNC_STAGES-th rising edge after it was presented.
- R3: In idle, a strobe pulse that sees the synchronised line at 0 begins start confirmation and counts as the first low sample. The start bit is accepted on the strobe that gives the START_LOW-th (default 4) consecutive low sample. A strobe that sees 1 before that point returns the block to idle, and no byte is produced.
- R4: Data bit 0 is sampled on the OVS-th (default 8) strobe after the strobe that accepted the start. Each later data bit, and then the stop bit, is sampled OVS strobes after the bit before it.
- R5: The first data bit received becomes bit 0 of `rx_byte` and the last becomes bit 7 (LSB first, LSB_FIRST=1).
- R6: On the clock edge of the stop-bit sample, the shift register is copied to `rx_byte` and `byte_full` becomes 1.
- R7: A one-cycle `host_rd_data` pulse clears `byte_full` at the next edge, unless a new byte is loaded on that same edge; in that case `byte_full` stays 1.
- R8: A byte that completes while `byte_full` is 1, with no `host_rd_data` in that cycle, sets `overrun` to 1 and still replaces `rx_byte`.
- R9: `overrun` stays 1 until a `host_rd_stat` pulse clears it. If a new overrun occurs in the same cycle as the pulse, the flag stays set.
- R10: Frames whose bit period is 2% longer or 2% shorter than nominal are received with the correct byte.
- R11: The framing state and its counters change only on clock edges where `tick_x8` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| tick_x8 | input | 1 | One-cycle sampling strobe, OVS pulses per bit period |
| host_rd_data | input | 1 | Host has taken `rx_byte`; clears `byte_full` |
| host_rd_stat | input | 1 | Host has read the status; clears `overrun` |
| rx_byte | output | DATA_W | Last completed byte |
| byte_full | output | 1 | An unacknowledged byte is held in `rx_byte` |
| overrun | output | 1 | Sticky flag: a byte was replaced before it was acknowledged |

## Verification
The bench builds the block with its default parameters: 8 data bits, 8 strobes per bit, 4 low samples to confirm a start, and a two-stage synchroniser. The strobe is generated as one pulse every four clocks, so the nominal bit lasts 32 clocks. With the strobe at that spacing, a deliberate 2% stretch or shrink of the bit period moves the stop-bit sample by more than one strobe slot, which puts the mid-bit margin to a real test. Glitches of two and three strobes exercise the false-start return path, and back-to-back unacknowledged frames exercise the overrun path.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE    = 2'd0,
      RX_CONFIRM = 2'd1,
      RX_SHIFT   = 2'd2
   } rx_state_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("serial_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
   import serial_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int OVS       = 8,
   parameter int START_LOW = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line_s,
   output logic              load,
   output logic [DATA_W-1:0] shreg
);
   localparam int TW = (OVS > 2) ? $clog2(OVS) : 1;
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [TW-1:0] T_LAST  = TW'(OVS - 1);
   localparam logic [TW-1:0] T_START = TW'(START_LOW - 1);
   localparam logic [BW-1:0] B_STOP  = BW'(DATA_W);

   generate
      if (START_LOW < 2 || START_LOW > OVS) begin : g_bad_start
         $error("serial_rx_framer: START_LOW must lie in 2..OVS");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_rx_framer: DATA_W must be at least 2");
      end
   endgenerate

   rx_state_t         state;
   logic [TW-1:0]     tcnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg_nxt;
   logic              bit_slot;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign shreg_nxt = {line_s, shreg[DATA_W-1:1]};
      end else begin : g_msb_first
         assign shreg_nxt = {shreg[DATA_W-2:0], line_s};
      end
   endgenerate

   assign bit_slot = tick && (state == RX_SHIFT) && (tcnt == T_LAST);
   assign load     = bit_slot && (bidx == B_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         tcnt  <= '0;
         bidx  <= '0;
         shreg <= '0;
      end else if (tick) begin
         unique case (state)
            RX_IDLE: begin
               if (!line_s) begin
                  state <= RX_CONFIRM;
                  tcnt  <= TW'(1);
               end
            end
            RX_CONFIRM: begin
               if (line_s) begin
                  state <= RX_IDLE;
                  tcnt  <= '0;
               end else if (tcnt == T_START) begin
                  state <= RX_SHIFT;
                  tcnt  <= '0;
                  bidx  <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            RX_SHIFT: begin
               if (tcnt == T_LAST) begin
                  tcnt <= '0;
                  if (bidx == B_STOP) begin
                     state <= RX_IDLE;
                  end else begin
                     shreg <= shreg_nxt;
                     bidx  <= bidx + 1'b1;
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R11: framing state only moves on a strobe
   p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(state) && $stable(tcnt) && $stable(bidx)));

   // R3: a high sample during confirmation abandons the start
   p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && state == RX_CONFIRM && line_s) |=> (state == RX_IDLE));

   // R3: confirmation is entered only from a low sample in idle
   p_confirm_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE) ##1 (state == RX_CONFIRM) |-> $past(tick && !line_s));

   // R4: shift register moves only on a data-bit slot
   p_shift_on_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_slot |=> $stable(shreg));
endmodule

// File: rtl/serial_rx_holder.sv
module serial_rx_holder #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_data,
   input  logic              rd_stat,
   output logic [DATA_W-1:0] dout,
   output logic              full,
   output logic              ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         full <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (load) dout <= din;
         full <= load ? 1'b1 : (rd_data ? 1'b0 : full);
         ovr  <= (load && full && !rd_data) ? 1'b1 : (rd_stat ? 1'b0 : ovr);
      end
   end

   p_load_sets_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (full && dout == $past(din)));

   p_read_clears_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !load) |=> !full);

   p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && full && !rd_data) |=> ovr);

   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !rd_stat) |=> ovr);
endmodule

// File: rtl/serial_rx_x8.sv
module serial_rx_x8 #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 8,
   parameter int START_LOW   = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_in,
   input  logic              tick_x8,
   input  logic              host_rd_data,
   input  logic              host_rd_stat,
   output logic [DATA_W-1:0] rx_byte,
   output logic              byte_full,
   output logic              overrun
);
   logic              line_s;
   logic              load;
   logic [DATA_W-1:0] shreg;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_in),
      .dout (line_s)
   );

   serial_rx_framer #(
      .DATA_W   (DATA_W),
      .OVS      (OVS),
      .START_LOW(START_LOW),
      .LSB_FIRST(LSB_FIRST)
   ) u_framer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_x8),
      .line_s(line_s),
      .load  (load),
      .shreg (shreg)
   );

   serial_rx_holder #(.DATA_W(DATA_W)) u_holder (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .din    (shreg),
      .rd_data(host_rd_data),
      .rd_stat(host_rd_stat),
      .dout   (rx_byte),
      .full   (byte_full),
      .ovr    (overrun)
   );

   // R1: outputs are clear in the first cycle after reset
   p_reset_clear_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!byte_full && !overrun && rx_byte == '0));
endmodule

// File: tb/serial_rx_x8_tb_top.sv
module serial_rx_x8_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic       tick_x8 = 1'b0;
   logic       host_rd_data = 1'b0;
   logic       host_rd_stat = 1'b0;
   logic [7:0] rx_byte;
   logic       byte_full;
   logic       overrun;

   int total = 0;
   int bad = 0;
   int wd = 0;
   bit done = 1'b0;
   int tdiv = 0;

   always #4 clk = ~clk;

   serial_rx_x8 dut_i (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick_x8(tick_x8),
      .host_rd_data(host_rd_data), .host_rd_stat(host_rd_stat),
      .rx_byte(rx_byte), .byte_full(byte_full), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // strobe: one pulse every 4 clocks (8 strobes = 32-clock bit)
   always @(negedge clk) begin
      tdiv    = (tdiv + 1) % 4;
      tick_x8 = (tdiv == 3);
   end

   // behavioural reference
   int         m_st, m_cnt, m_bit;
   logic [7:0] m_sr, m_dout;
   bit         m_full, m_ovr, m_s1, m_s2, m_ld;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_bit = 0; m_sr = 8'h00; m_dout = 8'h00;
         m_full = 0; m_ovr = 0; m_s1 = 1; m_s2 = 1; m_ld = 0;
      end else begin
         m_ld = 0;
         if (tick_x8) begin
            case (m_st)
               0: if (!m_s2) begin m_st = 1; m_cnt = 1; end
               1: begin
                  if (m_s2) m_st = 0;
                  else begin
                     m_cnt++;
                     if (m_cnt == 4) begin m_st = 2; m_cnt = 0; m_bit = 0; m_sr = 8'h00; end
                  end
               end
               default: begin
                  m_cnt++;
                  if (m_cnt == 8) begin
                     m_cnt = 0;
                     if (m_bit < 8) begin m_sr[m_bit] = m_s2; m_bit++; end
                     else begin m_ld = 1; m_st = 0; end
                  end
               end
            endcase
         end
         if (m_ld && m_full && !host_rd_data) m_ovr = 1;
         else if (host_rd_stat) m_ovr = 0;
         if (m_ld) begin m_full = 1; m_dout = m_sr; end
         else if (host_rd_data) m_full = 0;
         m_s2 = m_s1;
         m_s1 = rx_in;
      end
   end

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rx_byte == m_dout, "R2/R4/R5/R11 byte vs model", rx_byte, m_dout);
         chk(byte_full == m_full, "R6/R7 full vs model", byte_full, m_full);
         chk(overrun == m_ovr, "R8/R9 overrun vs model", overrun, m_ovr);
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd == 150000 && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected=<%0d", wd, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic send_frame(input logic [7:0] b, input real f, input int idle_bits);
      logic [9:0] bits = {1'b1, b, 1'b0};
      for (int k = 0; k < 10; k++) begin
         int t0 = $rtoi(k * 32.0 * f + 0.5);
         int t1 = $rtoi((k + 1) * 32.0 * f + 0.5);
         rx_in = bits[k];
         repeat (t1 - t0) @(negedge clk);
      end
      rx_in = 1'b1;
      repeat (idle_bits * 32) @(negedge clk);
   endtask

   task automatic read_data();
      host_rd_data = 1'b1;
      @(negedge clk);
      host_rd_data = 1'b0;
   endtask

   task automatic read_stat();
      host_rd_stat = 1'b1;
      @(negedge clk);
      host_rd_stat = 1'b0;
   endtask

   task automatic rx_and_check(input logic [7:0] b, input real f, input string req);
      send_frame(b, f, 1);
      chk(rx_byte == b, req, rx_byte, b);
      chk(byte_full == 1'b1, "R6 full after stop", byte_full, 1);
      read_data();
      chk(byte_full == 1'b0, "R7 full cleared by read", byte_full, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      // R1
      chk(rx_byte == 8'h00, "R1 byte at reset", rx_byte, 0);
      chk(!byte_full, "R1 full at reset", byte_full, 0);
      chk(!overrun, "R1 overrun at reset", overrun, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);

      // R5 R6 R7 nominal rate
      rx_and_check(8'h55, 1.0, "R5 nominal 55");
      rx_and_check(8'h01, 1.0, "R5 lsb first 01");
      rx_and_check(8'h80, 1.0, "R5 msb last 80");
      rx_and_check(8'h00, 1.0, "R4 all zero");
      rx_and_check(8'hFF, 1.0, "R4 all one");

      // R10 rate offset
      rx_and_check(8'hA3, 1.02, "R10 slow A3");
      rx_and_check(8'h5C, 1.02, "R10 slow 5C");
      rx_and_check(8'hA3, 0.98, "R10 fast A3");
      rx_and_check(8'h3E, 0.98, "R10 fast 3E");
      rx_and_check(8'hFE, 0.98, "R10 fast FE");

      // R3 false starts: low for 2 and 3 strobe slots
      rx_in = 1'b0; repeat (8) @(negedge clk); rx_in = 1'b1;
      repeat (100) @(negedge clk);
      chk(!byte_full, "R3 two-slot glitch ignored", byte_full, 0);
      chk(rx_byte == 8'hFE, "R3 byte untouched by glitch", rx_byte, 8'hFE);
      rx_in = 1'b0; repeat (12) @(negedge clk); rx_in = 1'b1;
      repeat (100) @(negedge clk);
      chk(!byte_full, "R3 three-slot glitch ignored", byte_full, 0);
      rx_and_check(8'h96, 1.0, "R3 frame after glitch");

      // R8 R9 overrun
      send_frame(8'h3C, 1.0, 1);
      chk(byte_full == 1'b1, "R6 first unread", byte_full, 1);
      chk(!overrun, "R8 no overrun yet", overrun, 0);
      send_frame(8'hC3, 1.0, 1);
      chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
      chk(rx_byte == 8'hC3, "R8 byte replaced", rx_byte, 8'hC3);
      read_data();
      chk(overrun == 1'b1, "R9 overrun survives data read", overrun, 1);
      read_stat();
      chk(!overrun, "R9 overrun cleared by status read", overrun, 0);
      rx_and_check(8'h69, 1.0, "R8 normal after overrun");
      chk(!overrun, "R8 no overrun on read frame", overrun, 0);

      repeat (20) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule